// File: doc/BRIEF.md
# Trip-Zone Flag and Interrupt Controller

This block keeps the trip status of one PWM channel. It holds two trip latches and one global interrupt flag. The one-shot latch stays set until software clears it. The cycle-by-cycle latch also clears by itself at a PWM period boundary once its trip input has dropped. A latch is set by a hardware trip strobe or by a software write to the force register. Software writes to the clear register to drop latches and to re-arm the interrupt.

The interrupt leaves the block as a one-clock pulse. A pulse is issued when a trip latch becomes set while the interrupt flag is clear. While the interrupt flag stays set, no further pulse is issued. If software clears the interrupt flag while a trip latch remains set, or is being set in the same cycle, a fresh pulse follows at once, so no pending trip can be lost. The register port is a plain single-cycle write/read port with 16-bit data. A read returns the flags combinationally.

Top module: `trip_flag_ctrl`

## Requirements
- R1: While reset is asserted, `flag_ost`, `flag_cbc`, `flag_int` and `trip_irq` are all 0.
- R2: A high `trip_ost_in` at a clock edge sets `flag_ost` at that edge. `flag_ost` then stays 1 until a software clear. The period strobe does not clear it.
- R3: A high `trip_cbc_in` at a clock edge sets `flag_cbc` at that edge. A `period_strobe` at an edge clears `flag_cbc` when `trip_cbc_in` is low at that edge, and keeps it set when `trip_cbc_in` is high.
- R4: A write to address 2 (force) with data bit 2 set sets `flag_ost`, and with data bit 1 set sets `flag_cbc`. Data bit 0 and zero bits have no effect. The interrupt flag cannot be forced.
- R5: A write to address 1 (clear) with data bit 2 set clears `flag_ost`, with data bit 1 set clears `flag_cbc`, and with data bit 0 set clears `flag_int`. Zero bits leave flags unchanged.
- R6: When a set (trip input or force) and a software clear hit the same latch at the same edge, the latch ends up set.
- R7: When a trip latch becomes set while `flag_int` is 0, `flag_int` and `trip_irq` both go to 1 at that same edge, and `trip_irq` returns to 0 on the next edge.
- R8: While `flag_int` stays 1, `trip_irq` stays 0, whatever trips occur.
- R9: A clear of `flag_int` while a trip latch remains set, or is set at that edge, produces a `trip_irq` pulse at that edge, and `flag_int` stays 1.
- R10: A single clear write with bits 2, 1 and 0 set (and no trip pending) leaves all flags 0 and produces no pulse.
- R11: `reg_rdata` at address 0 returns {13 zero bits, `flag_ost`, `flag_cbc`, `flag_int`} in bits 2, 1, 0. Reads at addresses 1 and 2 (and any other address) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one per cycle |
| reg_addr | input | ADDR_W | Register address: 0 flags, 1 clear, 2 force |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| trip_ost_in | input | 1 | One-shot trip strobe |
| trip_cbc_in | input | 1 | Cycle-by-cycle trip level/strobe |
| period_strobe | input | 1 | PWM period boundary strobe |
| flag_ost | output | 1 | One-shot trip latch |
| flag_cbc | output | 1 | Cycle-by-cycle trip latch |
| flag_int | output | 1 | Global interrupt flag |
| trip_irq | output | 1 | One-clock interrupt pulse |

## Verification
Every flag and the interrupt pulse is registered once. Each one takes effect at the first clock edge that samples its cause: a trip strobe, a force or clear write, or a period strobe. `reg_rdata` is combinational and follows the address within the same cycle. The bench drives each stimulus for exactly one cycle from the falling edge. It samples outputs one time unit after the next rising edge, so the flags and `trip_irq` are compared in the cycle they are due. A further idle cycle then shows that the pulse has dropped. Read checks move the address on the falling edge and compare before any rising edge.

// File: rtl/trip_flag_pkg.sv
package trip_flag_pkg;

  localparam int ADDR_FLAG = 0;
  localparam int ADDR_CLR  = 1;
  localparam int ADDR_FRC  = 2;

  localparam int POS_OST = 2;
  localparam int POS_CBC = 1;
  localparam int POS_INT = 0;
  localparam int NUM_FLAGS = 3;

  typedef struct packed {
    logic ost_frc;
    logic cbc_frc;
    logic ost_clr;
    logic cbc_clr;
    logic int_clr;
  } sw_cmd_t;

endpackage

// File: rtl/trip_reg_decode.sv
module trip_reg_decode
  import trip_flag_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output sw_cmd_t              cmd_o,
  output logic [DW-1:0]        rdata_o
);

  logic is_clr;
  logic is_frc;
  logic is_flag;
  logic wdata_unused;

  assign is_clr  = wr_en_i && (addr_i == AW'(ADDR_CLR));
  assign is_frc  = wr_en_i && (addr_i == AW'(ADDR_FRC));
  assign is_flag = (addr_i == AW'(ADDR_FLAG));

  assign wdata_unused = ^wdata_i[DW-1:NUM_FLAGS] ^ wdata_i[POS_INT];

  always_comb begin
    cmd_o         = '0;
    cmd_o.ost_clr = is_clr & wdata_i[POS_OST];
    cmd_o.cbc_clr = is_clr & wdata_i[POS_CBC];
    cmd_o.int_clr = is_clr & wdata_i[POS_INT];
    cmd_o.ost_frc = is_frc & wdata_i[POS_OST];
    cmd_o.cbc_frc = is_frc & wdata_i[POS_CBC];
  end

  always_comb begin
    rdata_o = '0;
    if (is_flag) begin
      rdata_o[NUM_FLAGS-1:0] = flags_i;
    end
  end

endmodule

// File: rtl/trip_latch.sv
module trip_latch #(
  parameter bit AUTO_CLR_EN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic sw_clr_i,
  input  logic auto_clr_i,
  output logic flag_d_o,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;
  logic clr_eff;
  logic upd_en;

  generate
    if (AUTO_CLR_EN) begin : g_auto
      assign clr_eff = sw_clr_i | auto_clr_i;
    end else begin : g_manual
      logic auto_unused;
      assign auto_unused = auto_clr_i;
      assign clr_eff     = sw_clr_i;
    end
  endgenerate

  always_comb begin
    flag_d = flag_q;
    if (clr_eff) flag_d = 1'b0;
    if (set_i)   flag_d = 1'b1;
  end

  assign upd_en = set_i | clr_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (upd_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_d_o = flag_d;
  assign flag_o   = flag_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !sw_clr_i && !(AUTO_CLR_EN && auto_clr_i)) |=> flag_o);

endmodule

// File: rtl/trip_irq_gen.sv
module trip_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic int_clr_i,
  input  logic trip_next_i,
  output logic int_o,
  output logic pulse_o
);

  logic int_q;
  logic pulse_q;
  logic int_eff;
  logic fire;
  logic int_d;

  always_comb begin
    int_eff = int_q & ~int_clr_i;
    fire    = ~int_eff & trip_next_i;
    int_d   = int_eff | fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      int_q   <= int_d;
      pulse_q <= fire;
    end
  end

  assign int_o   = int_q;
  assign pulse_o = pulse_q;

  // R7
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> int_o);

  // R8
  no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_o && !int_clr_i) |=> !pulse_o);

  // R9
  rearm_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_o && int_clr_i && trip_next_i) |=> (pulse_o && int_o));

  // R5
  int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_o && !int_clr_i) |=> int_o);

endmodule

// File: rtl/trip_flag_ctrl.sv
module trip_flag_ctrl
  import trip_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              trip_ost_in,
  input  logic              trip_cbc_in,
  input  logic              period_strobe,
  output logic              flag_ost,
  output logic              flag_cbc,
  output logic              flag_int,
  output logic              trip_irq
);

  logic                 rst_meta_n;
  logic                 rst_sync_n;
  sw_cmd_t              cmd;
  logic [NUM_FLAGS-1:0] flag_vec;
  logic                 ost_d;
  logic                 cbc_d;
  logic                 ost_q;
  logic                 cbc_q;
  logic                 int_q;
  logic                 irq_q;
  logic                 cbc_auto_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_comb begin
    flag_vec          = '0;
    flag_vec[POS_OST] = ost_q;
    flag_vec[POS_CBC] = cbc_q;
    flag_vec[POS_INT] = int_q;
  end

  trip_reg_decode #(
    .DW (DATA_W),
    .AW (ADDR_W)
  ) u_decode (
    .wr_en_i (reg_wr_en),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .flags_i (flag_vec),
    .cmd_o   (cmd),
    .rdata_o (reg_rdata)
  );

  assign cbc_auto_clr = period_strobe & ~trip_cbc_in;

  trip_latch #(
    .AUTO_CLR_EN (1'b0)
  ) u_ost_latch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .set_i      (trip_ost_in | cmd.ost_frc),
    .sw_clr_i   (cmd.ost_clr),
    .auto_clr_i (1'b0),
    .flag_d_o   (ost_d),
    .flag_o     (ost_q)
  );

  trip_latch #(
    .AUTO_CLR_EN (1'b1)
  ) u_cbc_latch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .set_i      (trip_cbc_in | cmd.cbc_frc),
    .sw_clr_i   (cmd.cbc_clr),
    .auto_clr_i (cbc_auto_clr),
    .flag_d_o   (cbc_d),
    .flag_o     (cbc_q)
  );

  trip_irq_gen u_irq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .int_clr_i   (cmd.int_clr),
    .trip_next_i (ost_d | cbc_d),
    .int_o       (int_q),
    .pulse_o     (irq_q)
  );

  assign flag_ost = ost_q;
  assign flag_cbc = cbc_q;
  assign flag_int = int_q;
  assign trip_irq = irq_q;

  // R11
  cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr != ADDR_W'(ADDR_FLAG)) |-> (reg_rdata == '0));

  // R3
  cbc_period_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (period_strobe && !trip_cbc_in && !cmd.cbc_frc) |=> !flag_cbc);

endmodule

// File: tb/trip_flag_ctrl_tb.sv
module trip_flag_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        trip_ost_in;
  logic        trip_cbc_in;
  logic        period_strobe;
  logic        flag_ost;
  logic        flag_cbc;
  logic        flag_int;
  logic        trip_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [1:0] A_FLAG = 2'd0;
  localparam logic [1:0] A_CLR  = 2'd1;
  localparam logic [1:0] A_FRC  = 2'd2;

  always #4 clk = ~clk;

  trip_flag_ctrl u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_en     (reg_wr_en),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .trip_ost_in   (trip_ost_in),
    .trip_cbc_in   (trip_cbc_in),
    .period_strobe (period_strobe),
    .flag_ost      (flag_ost),
    .flag_cbc      (flag_cbc),
    .flag_int      (flag_int),
    .trip_irq      (trip_irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [2:0] exp_f, input logic exp_irq);
    chk({tag, " flags"}, {13'd0, flag_ost, flag_cbc, flag_int}, {13'd0, exp_f});
    chk({tag, " irq"}, {15'd0, trip_irq}, {15'd0, exp_irq});
  endtask

  task automatic cyc(input logic wr, input logic [1:0] a, input logic [15:0] d,
                     input logic to, input logic tc, input logic pr);
    @(negedge clk);
    reg_wr_en     = wr;
    reg_addr      = a;
    reg_wdata     = d;
    trip_ost_in   = to;
    trip_cbc_in   = tc;
    period_strobe = pr;
    @(posedge clk);
    #1;
    reg_wr_en     = 1'b0;
    reg_wdata     = '0;
    trip_ost_in   = 1'b0;
    trip_cbc_in   = 1'b0;
    period_strobe = 1'b0;
  endtask

  task automatic idle();
    cyc(1'b0, A_FLAG, 16'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_wr_en = 1'b0;
    reg_addr  = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    trip_ost_in = 1'b0; trip_cbc_in = 1'b0; period_strobe = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk_out("R1 in reset", 3'b000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk_out("R1 after reset", 3'b000, 1'b0);
  endtask

  task automatic t_oneshot();
    cyc(1'b0, A_FLAG, 16'h0, 1'b1, 1'b0, 1'b0);
    chk_out("R2 R7 ost trip", 3'b101, 1'b1);
    idle();
    chk_out("R7 pulse one cycle", 3'b101, 1'b0);
    repeat (3) idle();
    chk_out("R2 ost holds", 3'b101, 1'b0);
    cyc(1'b0, A_FLAG, 16'h0, 1'b1, 1'b0, 1'b0);
    chk_out("R8 no refire", 3'b101, 1'b0);
    cyc(1'b1, A_CLR, 16'h0001, 1'b0, 1'b0, 1'b0);
    chk_out("R9 rearm pulse", 3'b101, 1'b1);
    idle();
    chk_out("R9 pulse drops", 3'b101, 1'b0);
    cyc(1'b1, A_CLR, 16'h0007, 1'b0, 1'b0, 1'b0);
    chk_out("R10 clear all", 3'b000, 1'b0);
    idle();
    chk_out("R10 quiet", 3'b000, 1'b0);
  endtask

  task automatic t_cycle();
    cyc(1'b0, A_FLAG, 16'h0, 1'b0, 1'b1, 1'b0);
    chk_out("R3 R7 cbc trip", 3'b011, 1'b1);
    cyc(1'b0, A_FLAG, 16'h0, 1'b0, 1'b1, 1'b1);
    chk_out("R3 strobe with trip high", 3'b011, 1'b0);
    cyc(1'b0, A_FLAG, 16'h0, 1'b0, 1'b0, 1'b1);
    chk_out("R3 strobe auto clear", 3'b001, 1'b0);
    idle();
    chk_out("R3 stays clear", 3'b001, 1'b0);
    cyc(1'b1, A_CLR, 16'h0001, 1'b0, 1'b0, 1'b0);
    chk_out("R5 int clear no trip", 3'b000, 1'b0);
  endtask

  task automatic t_force();
    cyc(1'b1, A_FRC, 16'h0001, 1'b0, 1'b0, 1'b0);
    chk_out("R4 force bit0 ignored", 3'b000, 1'b0);
    cyc(1'b1, A_FRC, 16'h0000, 1'b0, 1'b0, 1'b0);
    chk_out("R4 force zero ignored", 3'b000, 1'b0);
    cyc(1'b1, A_FRC, 16'h0004, 1'b0, 1'b0, 1'b0);
    chk_out("R4 force ost", 3'b101, 1'b1);
    cyc(1'b1, A_FRC, 16'h0002, 1'b0, 1'b0, 1'b0);
    chk_out("R4 R8 force cbc", 3'b111, 1'b0);
    cyc(1'b0, A_FLAG, 16'h0, 1'b0, 1'b0, 1'b1);
    chk_out("R2 R3 strobe spares ost", 3'b101, 1'b0);
    cyc(1'b1, A_FRC, 16'h0002, 1'b0, 1'b0, 1'b0);
    chk_out("R4 force cbc again", 3'b111, 1'b0);
    cyc(1'b1, A_CLR, 16'h0000, 1'b0, 1'b0, 1'b0);
    chk_out("R5 clear zero ignored", 3'b111, 1'b0);
    rd(A_FLAG, 16'h0007, "R11 read flags");
    rd(A_CLR, 16'h0000, "R11 read clear reg");
    rd(A_FRC, 16'h0000, "R11 read force reg");
    rd(2'd3, 16'h0000, "R11 read spare addr");
    cyc(1'b1, A_CLR, 16'h0002, 1'b0, 1'b0, 1'b0);
    chk_out("R5 clear cbc", 3'b101, 1'b0);
    cyc(1'b1, A_CLR, 16'h0004, 1'b0, 1'b0, 1'b0);
    chk_out("R5 clear ost", 3'b001, 1'b0);
    rd(A_FLAG, 16'h0001, "R11 read int only");
    cyc(1'b1, A_CLR, 16'h0001, 1'b0, 1'b0, 1'b0);
    chk_out("R5 clear int", 3'b000, 1'b0);
  endtask

  task automatic t_set_wins();
    cyc(1'b1, A_CLR, 16'h0004, 1'b1, 1'b0, 1'b0);
    chk_out("R6 ost set beats clear", 3'b101, 1'b1);
    cyc(1'b1, A_CLR, 16'h0002, 1'b0, 1'b1, 1'b0);
    chk_out("R6 cbc set beats clear", 3'b111, 1'b0);
    cyc(1'b1, A_CLR, 16'h0007, 1'b1, 1'b0, 1'b0);
    chk_out("R6 R9 clear all with ost trip", 3'b101, 1'b1);
    cyc(1'b1, A_CLR, 16'h0007, 1'b0, 1'b0, 1'b0);
    chk_out("R10 final clear", 3'b000, 1'b0);
  endtask

  initial begin
    t_reset();
    t_oneshot();
    t_cycle();
    t_force();
    t_set_wins();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule